// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This block multiplies two integer operands over several clock cycles. It handles one multiplier bit per cycle, from the least significant bit upward. It uses a single double-width register for all of its state. The multiplier starts in the lower half of that register and the partial product grows in the upper half. On each cycle the multiplicand is added into the upper half when the bit being examined is one. The whole register then shifts right by one place. The adder's extra top bit becomes the new most significant bit. Finished product bits collect in the lower half while the multiplier bits drain out of it.

A one-cycle `start` pulse captures both operands and a mode select. Unsigned mode treats the operands as plain binary values. Signed mode treats them as two's complement. In signed mode the partial product is sign-extended on every shift, and the final multiplier bit, which carries negative weight, is subtracted rather than added. The block raises `busy` while it works and pulses `done` once at the end. The product is presented as a high word and a low word and stays there until the next start.

Top module: `seq_mul`

## Requirements
- R1: A `start` pulse sampled while `busy` is low captures `a`, `b` and `sgn`, and `busy` is high from the next cycle.
- R2: `busy` stays high for exactly W cycles after the capturing edge. In the cycle after that, `busy` is low and `done` is high.
- R3: `done` is high for one cycle only, and never while `busy` is high.
- R4: With `sgn` = 0, `{hi, lo}` at `done` equals the exact unsigned 2W-bit product of `a` and `b`.
- R5: With `sgn` = 1, `{hi, lo}` at `done` equals the exact two's-complement 2W-bit product. This includes the most negative value times itself (0x80000000 squared gives 0x4000000000000000).
- R6: A `start` pulse while `busy` is high is ignored. Neither the result nor the length of the busy period changes.
- R7: While `busy` is low and `start` is low, `hi` and `lo` hold their value.
- R8: After reset, `busy`, `done`, `hi` and `lo` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiplication when idle |
| sgn | input | 1 | 1 = signed operands, 0 = unsigned |
| a | input | W | Multiplicand |
| b | input | W | Multiplier |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| hi | output | W | Upper word of the product |
| lo | output | W | Lower word of the product |

## Verification
The case hardest to reach is the last iteration in signed mode, where the top multiplier bit is subtracted. It only changes the result when `b` is negative. Its worst case is the most negative value times itself or times minus one. The stimulus sweeps every pair of small signed values sign-extended to the full width, so `b` has its top bit set in half the runs. It then crosses the boundary operands 0, 1, all-ones, 0x7FFFFFFF and 0x80000000 in both modes. Some runs inject a stray `start` partway through to show that it has no effect.

// File: rtl/seq_mul.sv
module seq_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         sgn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [2*W-1:0] acc;
  logic [W-1:0]   mcand;
  logic [CW-1:0]  cnt;
  logic           sgn_r;

  logic           last;
  logic [W:0]     hx, mx, sum;

  assign last = (cnt == CW'(W-1));
  assign hx   = {sgn_r & acc[2*W-1], acc[2*W-1:W]};
  assign mx   = {sgn_r & mcand[W-1], mcand};

  always_comb begin
    sum = hx;
    if (acc[0]) sum = (sgn_r && last) ? hx - mx : hx + mx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      mcand <= '0;
      cnt   <= '0;
      sgn_r <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          acc   <= {{W{1'b0}}, b};
          mcand <= a;
          sgn_r <= sgn;
          cnt   <= '0;
          busy  <= 1'b1;
        end
      end else begin
        acc <= {sum, acc[W-1:1]};
        cnt <= cnt + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign hi = acc[2*W-1:W];
  assign lo = acc[W-1:0];

  a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r2_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !last) |=> (busy && $stable(mcand)));
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable({hi, lo}));
endmodule

// File: tb/tb_seq_mul.sv
module tb_seq_mul;
  localparam int W = 32;

  logic clk = 0, rst_n = 0, start = 0, sgn = 0;
  logic [W-1:0] a = '0, b = '0;
  logic busy, done;
  logic [W-1:0] hi, lo;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  seq_mul #(.W(W)) dut (.clk(clk), .rst_n(rst_n), .start(start), .sgn(sgn),
    .a(a), .b(b), .busy(busy), .done(done), .hi(hi), .lo(lo));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<190000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y, input logic s);
    logic signed [2*W-1:0] sx, sy;
    logic [2*W-1:0] ux, uy;
    if (s) begin
      sx = {{W{x[W-1]}}, x};
      sy = {{W{y[W-1]}}, y};
      return sx * sy;
    end
    ux = {{W{1'b0}}, x};
    uy = {{W{1'b0}}, y};
    return ux * uy;
  endfunction

  task automatic run(input logic [W-1:0] x, input logic [W-1:0] y, input logic s, input bit inject);
    int n;
    logic [2*W-1:0] exp;
    exp = ref_mul(x, y, s);
    @(negedge clk);
    a = x; b = y; sgn = s; start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    if (inject) chk("R1", {127'b0, busy}, 128'd1);
    while (!done && n < 100) begin
      if (inject && n == 5) begin
        start = 1; a = ~x; b = ~y; sgn = ~s;
      end else start = 0;
      @(negedge clk);
      n++;
    end
    start = 0;
    if (inject) chk("R2 R6 busy length", 128'(n), 128'(W));
    chk("R3 busy low at done", {127'b0, busy}, 128'd0);
    chk(s ? "R5 signed product" : "R4 unsigned product", 128'({hi, lo}), 128'(exp));
    if (inject) begin
      @(negedge clk);
      chk("R3 done one cycle", {127'b0, done}, 128'd0);
      chk("R7 result held", 128'({hi, lo}), 128'(exp));
    end
  endtask

  initial begin
    logic [W-1:0] corner [5];
    corner[0] = 32'h0; corner[1] = 32'h1; corner[2] = 32'hFFFF_FFFF;
    corner[3] = 32'h7FFF_FFFF; corner[4] = 32'h8000_0000;
    repeat (3) @(negedge clk);
    chk("R8 reset state", 128'({busy, done, hi, lo}), 128'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R8 idle after reset", 128'({busy, done, hi, lo}), 128'd0);
    for (int s = 0; s < 2; s++)
      for (int i = -8; i < 8; i++)
        for (int j = -8; j < 8; j++)
          run(W'(i), W'(j), s[0], (i == j));
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          run(corner[i], corner[j], s[0], 1);
    run(32'h8000_0000, 32'h8000_0000, 1'b1, 1);
    chk("R5 min squared", 128'({hi, lo}), 128'(64'h4000_0000_0000_0000));
    for (int k = 0; k < 200; k++)
      run($urandom, $urandom, k[0], k[2]);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule